// File: doc/BRIEF.md
# Per-Flow Packet Order Tracker

This block keeps control packets leaving a router in the order they arrived, even though a packet may wait in any of three separate internal stores: a side-network buffer, an intermediate buffer, or a virtual-channel buffer of the main network. It issues no storage of its own. It holds an ordering context for every combination of input port, output port and message class. Each context is a pair of ticket counters: an arrival counter and a departure counter.

When a packet arrives, the block hands back a sequence tag, which is the arrival counter of the packet's flow, and then advances that counter. When a buffer wants to release a packet, it presents the flow and the tag. The block grants release only if the tag equals the flow's departure counter. When the release is confirmed, the departure counter advances. Each input port can present one arrival and one departure per cycle. Its flows belong to it alone, so the ports never contend.

Top module: `pkt_order_tracker`

## Requirements
- R1: After reset every flow is empty. The first accepted arrival on any flow returns tag 0. No departure is granted on an empty flow.
- R2: An arrival that is accepted raises `arr_acc_q` for one cycle on the next clock edge. `arr_tag_q` then carries the flow's arrival count before the arrival. The flow's next arrival gets that value plus one. When no arrival is accepted, `arr_tag_q` is 0.
- R3: The buffer-kind code on `arr_buf` (0 side buffer, 1 intermediate buffer, 2 main-network VC buffer) has no effect on tags or on acceptance.
- R4: `dep_ok` is combinational. It is high exactly when `dep_req` is high, the selected flow holds at least one packet, and `dep_tag` equals that flow's departure count.
- R5: The departure count of a flow advances by one only in a cycle where `dep_req`, `dep_go` and `dep_ok` are all high. A `dep_go` without a grant is ignored.
- R6: A flow is selected by the input port together with the output-port and class fields. Activity on one flow never changes the tags or grants of any other flow, including a flow that differs only in class.
- R7: Tags are `TAG_W` bits wide and wrap modulo 2^TAG_W. Ordering stays correct across the wrap.
- R8: An arrival on a flow that already holds `CAP` packets is rejected. On the next edge `arr_rej_q` is 1 and `arr_acc_q` is 0, and the arrival count is unchanged. A departure in the same cycle does not make room for that arrival.
- R9: An arrival and a confirmed departure on the same flow in the same cycle both take effect. A packet that arrives on an empty flow can be granted in the cycle after its arrival.
- R10: A synchronous active-high reset clears every counter and every registered output, including in the middle of traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arr_vld | input | NUM_IN | Arrival strobe, one bit per input port |
| arr_out | input | NUM_IN*OW | Output-port field of each arrival |
| arr_vc | input | NUM_IN*VW | Message-class field of each arrival |
| arr_buf | input | NUM_IN*2 | Buffer-kind code of each arrival (does not affect ordering) |
| arr_acc_q | output | NUM_IN | Arrival accepted (registered) |
| arr_rej_q | output | NUM_IN | Arrival rejected, flow full (registered) |
| arr_tag_q | output | NUM_IN*TAG_W | Sequence tag of an accepted arrival (registered) |
| dep_req | input | NUM_IN | Departure permission request per input port |
| dep_out | input | NUM_IN*OW | Output-port field of the departing packet |
| dep_vc | input | NUM_IN*VW | Message-class field of the departing packet |
| dep_tag | input | NUM_IN*TAG_W | Sequence tag of the departing packet |
| dep_go | input | NUM_IN | Departure confirmed this cycle |
| dep_ok | output | NUM_IN | Departure permitted (combinational) |

## Verification
The bench drives one flow up to capacity and then offers an arrival and a departure together. A design that let the departure free a slot would accept an arrival it should refuse. It runs more than 2^TAG_W packets through one flow, which catches a design that compares tags without wrapping. It asks for a grant in the cycle right after an arrival on an empty flow, where a design with an extra pipeline stage would withhold the grant. It confirms departures that were never granted, which a careless design would let advance the departure count. Random traffic on all ports and classes, with varied buffer codes, checks against a reference model that a design leaking state between flows or classes would hand out wrong tags.

// File: rtl/ord_pkg.sv
package ord_pkg;
  // Which store holds the packet; the ordering logic treats all of them alike.
  typedef enum logic [1:0] {
    BUF_SIDE = 2'd0,
    BUF_MID  = 2'd1,
    BUF_MAIN = 2'd2,
    BUF_RSVD = 2'd3
  } buf_kind_e;

  function automatic int fld_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ord_flow_ctr.sv
module ord_flow_ctr #(
  parameter int TAG_W = 3,
  parameter int CAP   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arr_hit,
  input  logic             dep_hit,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full,
  output logic             empty
);
  localparam logic [TAG_W-1:0] CAP_V = TAG_W'(CAP);
  localparam logic [TAG_W-1:0] ONE   = TAG_W'(1);

  logic [TAG_W-1:0] head_q, tail_q, occ;

  assign occ   = head_q - tail_q;
  assign full  = (occ == CAP_V);
  assign empty = (occ == '0);
  assign head  = head_q;
  assign tail  = tail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (arr_hit && !full)  head_q <= head_q + ONE;
      if (dep_hit && !empty) tail_q <= tail_q + ONE;
    end
  end

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
    (arr_hit && !full) |=> (head_q == $past(head_q) + ONE)); // R2
  AST_TAIL_STEP: assert property (@(posedge clk) disable iff (rst)
    (dep_hit && !empty) |=> (tail_q == $past(tail_q) + ONE)); // R5
  AST_OCC_CAP: assert property (@(posedge clk) disable iff (rst)
    (occ <= CAP_V)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!arr_hit && !dep_hit) |=> ($stable(head_q) && $stable(tail_q))); // R6
  AST_RST_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (head_q == '0 && tail_q == '0)); // R10
endmodule

// File: rtl/ord_in_port.sv
module ord_in_port
  import ord_pkg::*;
#(
  parameter  int NUM_OUT = 4,
  parameter  int NUM_VC  = 2,
  parameter  int TAG_W   = 3,
  parameter  int CAP     = 6,
  localparam int OW      = fld_w(NUM_OUT),
  localparam int VW      = fld_w(NUM_VC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arr_vld,
  input  logic [OW-1:0]    arr_out,
  input  logic [VW-1:0]    arr_vc,
  input  logic [1:0]       arr_buf,
  output logic             arr_acc_q,
  output logic             arr_rej_q,
  output logic [TAG_W-1:0] arr_tag_q,
  input  logic             dep_req,
  input  logic [OW-1:0]    dep_out,
  input  logic [VW-1:0]    dep_vc,
  input  logic [TAG_W-1:0] dep_tag,
  input  logic             dep_go,
  output logic             dep_ok
);
  localparam int NFL = NUM_OUT * NUM_VC;
  localparam int FW  = fld_w(NFL);

  logic [TAG_W-1:0] head_v [NFL];
  logic [TAG_W-1:0] tail_v [NFL];
  logic [NFL-1:0]   full_v, empty_v, arr_hit_v, dep_hit_v;
  logic [FW-1:0]    a_idx, d_idx;
  logic             a_full;

  assign a_idx  = FW'(arr_out) * FW'(NUM_VC) + FW'(arr_vc);
  assign d_idx  = FW'(dep_out) * FW'(NUM_VC) + FW'(dep_vc);
  assign a_full = full_v[a_idx];
  assign dep_ok = dep_req && !empty_v[d_idx] && (dep_tag == tail_v[d_idx]);

  for (genvar f = 0; f < NFL; f++) begin : g_flow
    assign arr_hit_v[f] = arr_vld && (a_idx == FW'(f));
    assign dep_hit_v[f] = dep_ok && dep_go && (d_idx == FW'(f));
    ord_flow_ctr #(.TAG_W(TAG_W), .CAP(CAP)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .arr_hit (arr_hit_v[f]),
      .dep_hit (dep_hit_v[f]),
      .head    (head_v[f]),
      .tail    (tail_v[f]),
      .full    (full_v[f]),
      .empty   (empty_v[f])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_acc_q <= 1'b0;
      arr_rej_q <= 1'b0;
      arr_tag_q <= '0;
    end else begin
      arr_acc_q <= arr_vld && !a_full;
      arr_rej_q <= arr_vld && a_full;
      arr_tag_q <= (arr_vld && !a_full) ? head_v[a_idx] : '0;
    end
  end

  AST_ONE_FLOW: assert property (@(posedge clk) disable iff (rst)
    $onehot0(arr_hit_v) && $onehot0(dep_hit_v)); // R6
  AST_ACC_XOR_REJ: assert property (@(posedge clk) disable iff (rst)
    !(arr_acc_q && arr_rej_q)); // R8
  AST_OK_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    dep_ok |-> (head_v[d_idx] != tail_v[d_idx])); // R4
  AST_BUF_LEGAL: assert property (@(posedge clk) disable iff (rst)
    arr_vld |-> (arr_buf != BUF_RSVD)); // R3
endmodule

// File: rtl/pkt_order_tracker.sv
module pkt_order_tracker
  import ord_pkg::*;
#(
  parameter  int NUM_IN  = 4,
  parameter  int NUM_OUT = 4,
  parameter  int NUM_VC  = 2,
  parameter  int TAG_W   = 3,
  parameter  int CAP     = 6,
  localparam int OW      = fld_w(NUM_OUT),
  localparam int VW      = fld_w(NUM_VC)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_IN-1:0]       arr_vld,
  input  logic [NUM_IN*OW-1:0]    arr_out,
  input  logic [NUM_IN*VW-1:0]    arr_vc,
  input  logic [NUM_IN*2-1:0]     arr_buf,
  output logic [NUM_IN-1:0]       arr_acc_q,
  output logic [NUM_IN-1:0]       arr_rej_q,
  output logic [NUM_IN*TAG_W-1:0] arr_tag_q,
  input  logic [NUM_IN-1:0]       dep_req,
  input  logic [NUM_IN*OW-1:0]    dep_out,
  input  logic [NUM_IN*VW-1:0]    dep_vc,
  input  logic [NUM_IN*TAG_W-1:0] dep_tag,
  input  logic [NUM_IN-1:0]       dep_go,
  output logic [NUM_IN-1:0]       dep_ok
);
  // Each input port owns the flows keyed by its own index, so ports never share state.
  for (genvar p = 0; p < NUM_IN; p++) begin : g_port
    ord_in_port #(
      .NUM_OUT (NUM_OUT),
      .NUM_VC  (NUM_VC),
      .TAG_W   (TAG_W),
      .CAP     (CAP)
    ) u_port (
      .clk       (clk),
      .rst       (rst),
      .arr_vld   (arr_vld[p]),
      .arr_out   (arr_out[p*OW +: OW]),
      .arr_vc    (arr_vc[p*VW +: VW]),
      .arr_buf   (arr_buf[p*2 +: 2]),
      .arr_acc_q (arr_acc_q[p]),
      .arr_rej_q (arr_rej_q[p]),
      .arr_tag_q (arr_tag_q[p*TAG_W +: TAG_W]),
      .dep_req   (dep_req[p]),
      .dep_out   (dep_out[p*OW +: OW]),
      .dep_vc    (dep_vc[p*VW +: VW]),
      .dep_tag   (dep_tag[p*TAG_W +: TAG_W]),
      .dep_go    (dep_go[p]),
      .dep_ok    (dep_ok[p])
    );
  end
endmodule

// File: tb/sim_pkt_order_tracker.sv
module sim_pkt_order_tracker;
  localparam int CLK_P = 10;
  localparam int NI = 4, NO = 4, NV = 2, TW = 3, CAP = 6;
  localparam int OW = 2, VW = 1, NF = NO * NV, MOD = 1 << TW;

  logic clk = 1'b0, rst = 1'b1;
  logic [NI-1:0]    arr_vld = '0, arr_acc_q, arr_rej_q, dep_req = '0, dep_go = '0, dep_ok;
  logic [NI*OW-1:0] arr_out = '0, dep_out = '0;
  logic [NI*VW-1:0] arr_vc = '0, dep_vc = '0;
  logic [NI*2-1:0]  arr_buf = '0;
  logic [NI*TW-1:0] arr_tag_q, dep_tag = '0;

  pkt_order_tracker #(.NUM_IN(NI), .NUM_OUT(NO), .NUM_VC(NV), .TAG_W(TW), .CAP(CAP)) u0 (
    .clk(clk), .rst(rst), .arr_vld(arr_vld), .arr_out(arr_out), .arr_vc(arr_vc),
    .arr_buf(arr_buf), .arr_acc_q(arr_acc_q), .arr_rej_q(arr_rej_q), .arr_tag_q(arr_tag_q),
    .dep_req(dep_req), .dep_out(dep_out), .dep_vc(dep_vc), .dep_tag(dep_tag),
    .dep_go(dep_go), .dep_ok(dep_ok));

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_bad = 0;
  bit done = 0;
  int hd [NI][NF];
  int tl [NI][NF];
  int e_acc [NI], e_rej [NI], e_tag [NI];
  int n_av [NI], n_ao [NI], n_avc [NI], n_ab [NI];
  int n_dr [NI], n_do [NI], n_dvc [NI], n_dt [NI], n_dg [NI];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int occ(input int p, input int f);
    return (hd[p][f] - tl[p][f] + MOD) % MOD;
  endfunction

  task automatic idle();
    for (int p = 0; p < NI; p++) begin
      n_av[p] = 0; n_ao[p] = 0; n_avc[p] = 0; n_ab[p] = 0;
      n_dr[p] = 0; n_do[p] = 0; n_dvc[p] = 0; n_dt[p] = 0; n_dg[p] = 0;
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NI; p++) begin
      e_acc[p] = 0; e_rej[p] = 0; e_tag[p] = 0;
      for (int f = 0; f < NF; f++) begin hd[p][f] = 0; tl[p][f] = 0; end
    end
  endtask

  // One cycle: check last edge's registered results, drive, check grants, update model.
  task automatic tick(input string tg);
    int af, df, eok, fullb;
    @(negedge clk);
    for (int p = 0; p < NI; p++) begin
      chk(arr_acc_q[p] == e_acc[p][0], {tg, " R2 acc"}, int'(arr_acc_q[p]), e_acc[p]);
      chk(arr_rej_q[p] == e_rej[p][0], {tg, " R8 rej"}, int'(arr_rej_q[p]), e_rej[p]);
      chk(int'(arr_tag_q[p*TW +: TW]) == e_tag[p], {tg, " R2 tag"},
          int'(arr_tag_q[p*TW +: TW]), e_tag[p]);
    end
    for (int p = 0; p < NI; p++) begin
      arr_vld[p] = n_av[p][0];  arr_out[p*OW +: OW] = OW'(n_ao[p]);
      arr_vc[p*VW +: VW] = VW'(n_avc[p]); arr_buf[p*2 +: 2] = 2'(n_ab[p]);
      dep_req[p] = n_dr[p][0];  dep_out[p*OW +: OW] = OW'(n_do[p]);
      dep_vc[p*VW +: VW] = VW'(n_dvc[p]); dep_tag[p*TW +: TW] = TW'(n_dt[p]);
      dep_go[p] = n_dg[p][0];
    end
    #1;
    for (int p = 0; p < NI; p++) begin
      af = n_ao[p] * NV + n_avc[p];
      df = n_do[p] * NV + n_dvc[p];
      eok = (n_dr[p] != 0 && occ(p, df) != 0 && n_dt[p] == tl[p][df]) ? 1 : 0;
      chk(dep_ok[p] == eok[0], {tg, " R4 dep_ok"}, int'(dep_ok[p]), eok);
      fullb = (occ(p, af) == CAP) ? 1 : 0;
      e_acc[p] = (n_av[p] != 0 && fullb == 0) ? 1 : 0;
      e_rej[p] = (n_av[p] != 0 && fullb == 1) ? 1 : 0;
      e_tag[p] = e_acc[p] ? hd[p][af] : 0;
      if (e_acc[p] != 0) hd[p][af] = (hd[p][af] + 1) % MOD;
      if (eok != 0 && n_dg[p] != 0) tl[p][df] = (tl[p][df] + 1) % MOD;   // R5
    end
  endtask

  task automatic arrive0(input int o, input int v, input int b);
    n_av[0] = 1; n_ao[0] = o; n_avc[0] = v; n_ab[0] = b;
  endtask

  task automatic depart0(input int o, input int v, input int t, input int g);
    n_dr[0] = 1; n_do[0] = o; n_dvc[0] = v; n_dt[0] = t; n_dg[0] = g;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++; n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); model_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 / R10: outputs clear after reset and no empty flow grants
    chk(arr_acc_q == '0 && arr_rej_q == '0, "R10 outputs clear", int'(arr_acc_q), 0);
    chk(arr_tag_q == '0, "R10 tag clear", int'(arr_tag_q), 0);
    for (int f = 0; f < NF; f++) begin
      idle(); depart0(f / NV, f % NV, 0, 1); tick("R1 empty");
    end

    // R9: arrival on empty flow, grantable next cycle; then arrival+departure together
    idle(); arrive0(1, 1, 0); tick("R9 a");
    idle(); depart0(1, 1, 0, 1); tick("R9 b");
    idle(); arrive0(1, 1, 1); tick("R9 c");
    idle(); arrive0(1, 1, 2); depart0(1, 1, 1, 1); tick("R9 same");
    idle(); depart0(1, 1, 2, 1); tick("R9 d");

    // R3: buffer kind does not matter; R6: class neighbour independent
    idle(); arrive0(2, 0, 2); tick("R3 a");
    idle(); arrive0(2, 0, 0); tick("R3 b");
    idle(); arrive0(2, 1, 1); tick("R6 other class");

    // R8: fill flow (3,0) to capacity, then reject even with a same-cycle departure
    for (int k = 0; k < CAP; k++) begin idle(); arrive0(3, 0, k % 3); tick("R8 fill"); end
    idle(); arrive0(3, 0, 0); tick("R8 full");
    idle(); arrive0(3, 0, 1); depart0(3, 0, 0, 1); tick("R8 full+dep");
    // R5: wrong tag and go without grant are ignored
    idle(); depart0(3, 0, 3, 1); tick("R5 wrong tag");
    idle(); depart0(3, 0, 1, 0); tick("R5 no go");
    for (int k = 1; k < CAP; k++) begin idle(); depart0(3, 0, k, 1); tick("R5 drain"); end

    // R7: wrap many times on flow (0,1)
    for (int k = 0; k < 3 * MOD; k++) begin
      idle(); arrive0(0, 1, k % 3); tick("R7 a");
      idle(); depart0(0, 1, tl[0][1], 1); tick("R7 d");
    end

    // R6: random traffic on all ports checked against the model
    for (int c = 0; c < 4000; c++) begin
      int pd;
      pd = (c < 2000) ? 60 : 25;
      idle();
      for (int p = 0; p < NI; p++) begin
        n_av[p] = ($urandom % 100) < 50;
        n_ao[p] = $urandom % NO; n_avc[p] = $urandom % NV; n_ab[p] = $urandom % 3;
        n_dr[p] = ($urandom % 100) < pd;
        n_do[p] = $urandom % NO; n_dvc[p] = $urandom % NV;
        n_dt[p] = (($urandom % 4) != 0) ? tl[p][n_do[p] * NV + n_dvc[p]] : int'($urandom % MOD);
        n_dg[p] = ($urandom % 100) < 75;
      end
      tick("R6 random");
    end

    // R10: reset in mid-traffic clears all flows
    idle(); tick("R10 pre");
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    idle(); arrive0(3, 0, 0); tick("R10 post");
    idle(); tick("R10 tag0");
    idle(); tick("R10 end");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule